// File: doc/BRIEF.md
# Power-Stage Control and Overcurrent Status Registers

This block sits on a byte-wide register bus inside a motor-driver companion device. A control register holds a master switch for the power outputs, a two-bit choice of LIN transmitter edge rate, and a command bit that asks the device to enter its low-power stop state. That command clears itself when any interrupt request arrives.

A status register latches overcurrent events from four power outputs: the H-bridge, the high-side driver, the high-voltage supply output and the Hall-sensor inputs. While a latched event is pending, its output stays switched off. Software clears the event, and so re-enables the output, by writing a one to the flag's bit. The same register shows live copies of the LIN current-limit, low-voltage, high-voltage and thermal indications.

Each output-enable line is the master switch gated by the inverse of its own flag. It is taken from a register so that it cannot glitch.

Top module: `pwr_fault_regs`

## Requirements
- R1: After reset, the master enable, the slew selection, the stop request, every overcurrent flag and every output enable are 0, and a read of either register returns 0x00 while the live inputs are low.
- R2: A write to address 0x03 loads the master enable from data bit 7 and the slew selection from bits 6:5. The slew codes are 00 = nominal 20 kBaud, 01 = slow 10 kBaud, 10 = fast 8x and 11 = fast 4x. The new values appear on `stage_en` and `slew_sel` after that clock edge, and a read of 0x03 returns them in the same positions with bits 4:0 as 0.
- R3: A write to 0x03 with data bit 4 set raises `stop_req` at that clock edge. Writing 0 to bit 4 leaves `stop_req` unchanged, and bit 4 always reads back as 0.
- R4: `irq_req` high at a clock edge clears `stop_req`, and it takes priority over a stop command written at the same edge.
- R5: An overcurrent event input high at a clock edge sets its flag. The flag stays set until it is cleared.
- R6: A write to address 0x0C with a one in a flag's bit position clears that flag. A zero in that position leaves it unchanged.
- R7: When an event input is high at the same edge as a write that clears its flag, the flag stays set.
- R8: `out_en[i]` is registered. After each clock edge it equals the master enable AND NOT flag i, both as updated by that edge. The index i is 0 for the H-bridge, 1 for the high side, 2 for the supply output and 3 for the Hall inputs.
- R9: A read of 0x0C returns, from bit 7 down to bit 0: Hall flag, LIN current limit, supply-output flag, high-side flag, low voltage, high voltage, H-bridge flag, thermal. The live bits follow their inputs in the same cycle.
- R10: `bus_rdata` is 0 while `bus_rd` is low, and reads of any other address return 0. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_rdata | output | 8 | Read data |
| oc_event | input | 4 | Overcurrent events: 0 H-bridge, 1 high side, 2 supply output, 3 Hall inputs |
| lin_cur_lim | input | 1 | Live LIN transmitter current-limit indication |
| low_volt | input | 1 | Low-voltage flag from the interrupt logic |
| high_volt | input | 1 | High-voltage flag from the interrupt logic |
| therm_flag | input | 1 | Thermal flag from the interrupt logic |
| irq_req | input | 1 | Interrupt request; clears the stop command |
| stage_en | output | 1 | Master power-stage enable |
| slew_sel | output | 2 | LIN slew-rate selection |
| stop_req | output | 1 | Request to enter stop mode |
| out_en | output | 4 | Per-output enables, gated by the flags |

## Verification
The bench builds the block with its defaults: an 8-bit bus, the control register at 0x03, the status register at 0x0C, and the registered output-enable variant. With these values the flag bits sit at 7, 5, 4 and 1, between the live bits. A write of 0xFD or 0x00 to the status register therefore shows whether the clear decode touches only the intended flag. Directed writes reach the clear-versus-set race and the race between an interrupt and a stop command. A random phase then makes the stop command, the clears and new events meet at the same edges many times.

// File: rtl/pwr_fault_pkg.sv
package pwr_fault_pkg;

   typedef enum logic [1:0] {
      SLEW_NOMINAL = 2'b00,
      SLEW_SLOW    = 2'b01,
      SLEW_FAST8   = 2'b10,
      SLEW_FAST4   = 2'b11
   } slew_mode_e;

   localparam int OC_NUM  = 4;
   localparam int OC_HB   = 0;
   localparam int OC_HS   = 1;
   localparam int OC_SUP  = 2;
   localparam int OC_HALL = 3;

   // control register fields
   localparam int CT_EN      = 7;
   localparam int CT_SLEW_LO = 5;
   localparam int CT_STOP    = 4;

   // status register live fields
   localparam int ST_THERM = 0;
   localparam int ST_HV    = 2;
   localparam int ST_LV    = 3;
   localparam int ST_LINCL = 6;

   // bit position of each overcurrent flag in the status register
   function automatic int oc_bit(input int idx);
      case (idx)
         OC_HB:   return 1;
         OC_HS:   return 4;
         OC_SUP:  return 5;
         default: return 7;
      endcase
   endfunction

endpackage

// File: rtl/pfr_ctrl_reg.sv
module pfr_ctrl_reg
   import pwr_fault_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_hit,
   input  logic [DW-1:0] wdata,
   input  logic          irq_req,
   output logic          stage_en,
   output logic          stage_en_nxt,
   output slew_mode_e    slew,
   output logic          stop_req
);

   logic stop_cmd;
   assign stop_cmd     = wr_hit & wdata[CT_STOP];
   assign stage_en_nxt = wr_hit ? wdata[CT_EN] : stage_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_en <= 1'b0;
         slew     <= SLEW_NOMINAL;
      end else if (wr_hit) begin
         stage_en <= wdata[CT_EN];
         slew     <= slew_mode_e'(wdata[CT_SLEW_LO +: 2]);
      end
   end

   // an interrupt request outranks a stop command at the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stop_req <= 1'b0;
      else if (irq_req)  stop_req <= 1'b0;
      else if (stop_cmd) stop_req <= 1'b1;
   end

   AST_SLEW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(slew) && $stable(stage_en)); // R2
   AST_STOP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wdata[CT_STOP] && !irq_req) |=> stop_req); // R3
   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !irq_req) |=> stop_req); // R3
   AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> !stop_req); // R4

endmodule

// File: rtl/pfr_oc_latch.sv
module pfr_oc_latch #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic clr,
   input  logic gate_en,
   output logic flag,
   output logic out_en
);

   logic flag_nxt;
   // a pending event always wins over a clear
   assign flag_nxt = evt | (flag & ~clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= flag_nxt;
   end

   generate
      if (REG_OUT) begin : g_reg
         // gate_en is the next-state master enable here
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_en <= 1'b0;
            else        out_en <= gate_en & ~flag_nxt;
         end
      end else begin : g_comb
         // gate_en is the current master enable here
         assign out_en = gate_en & ~flag;
      end
   endgenerate

   AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> flag); // R5
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag); // R5
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt) |=> !flag); // R6
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && clr) |=> flag); // R7
   AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      flag |-> !out_en); // R8

endmodule

// File: rtl/pfr_read_mux.sv
module pfr_read_mux
   import pwr_fault_pkg::*;
#(
   parameter int          DW        = 8,
   parameter int          AW        = 8,
   parameter logic [AW-1:0] CTRL_ADR = 8'h03,
   parameter logic [AW-1:0] STAT_ADR = 8'h0C
) (
   input  logic              rd,
   input  logic [AW-1:0]     addr,
   input  logic              stage_en,
   input  slew_mode_e        slew,
   input  logic [OC_NUM-1:0] flags,
   input  logic              lin_cl,
   input  logic              lv,
   input  logic              hv,
   input  logic              therm,
   output logic [DW-1:0]     rdata
);

   logic [DW-1:0] ctrl_word;
   logic [DW-1:0] stat_word;

   always_comb begin
      ctrl_word                      = '0;
      ctrl_word[CT_EN]               = stage_en;
      ctrl_word[CT_SLEW_LO +: 2]     = slew;
   end

   always_comb begin
      stat_word           = '0;
      stat_word[ST_THERM] = therm;
      stat_word[ST_HV]    = hv;
      stat_word[ST_LV]    = lv;
      stat_word[ST_LINCL] = lin_cl;
      for (int i = 0; i < OC_NUM; i++) stat_word[oc_bit(i)] = flags[i];
   end

   always_comb begin
      rdata = '0;
      if (rd) begin
         if (addr == CTRL_ADR)      rdata = ctrl_word;
         else if (addr == STAT_ADR) rdata = stat_word;
      end
   end

endmodule

// File: rtl/pwr_fault_regs.sv
module pwr_fault_regs
   import pwr_fault_pkg::*;
#(
   parameter int            DATA_W     = 8,
   parameter int            ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h03,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0C,
   parameter bit            REG_OUT_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  bus_addr,
   input  logic [7:0]  bus_wdata,
   input  logic        bus_wr,
   input  logic        bus_rd,
   output logic [7:0]  bus_rdata,
   input  logic [3:0]  oc_event,
   input  logic        lin_cur_lim,
   input  logic        low_volt,
   input  logic        high_volt,
   input  logic        therm_flag,
   input  logic        irq_req,
   output logic        stage_en,
   output logic [1:0]  slew_sel,
   output logic        stop_req,
   output logic [3:0]  out_en
);

   localparam int NUM_OC = OC_NUM;

   generate
      if (DATA_W != 8) begin : g_bad_dw
         $error("pwr_fault_regs: register layout needs DATA_W of 8");
      end
      if (ADDR_W != 8) begin : g_bad_aw
         $error("pwr_fault_regs: port list is built for ADDR_W of 8");
      end
      if (CTRL_ADDR == STAT_ADDR) begin : g_bad_map
         $error("pwr_fault_regs: register addresses must differ");
      end
   endgenerate

   logic              ctrl_wr;
   logic              stat_wr;
   logic              en_nxt;
   logic              gate_en;
   slew_mode_e        slew;
   logic [NUM_OC-1:0] flags;
   logic              unused_wdata;

   assign ctrl_wr      = bus_wr && (bus_addr == CTRL_ADDR);
   assign stat_wr      = bus_wr && (bus_addr == STAT_ADDR);
   assign unused_wdata = ^{bus_wdata[3:2], bus_wdata[0]};

   pfr_ctrl_reg #(.DW(DATA_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_hit       (ctrl_wr),
      .wdata        (bus_wdata),
      .irq_req      (irq_req),
      .stage_en     (stage_en),
      .stage_en_nxt (en_nxt),
      .slew         (slew),
      .stop_req     (stop_req)
   );

   assign slew_sel = slew;

   generate
      if (REG_OUT_EN) begin : g_gate_next
         assign gate_en = en_nxt;
      end else begin : g_gate_now
         assign gate_en = stage_en;
      end
   endgenerate

   for (genvar gi = 0; gi < NUM_OC; gi++) begin : g_oc
      pfr_oc_latch #(.REG_OUT(REG_OUT_EN)) u_latch (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt     (oc_event[gi]),
         .clr     (stat_wr & bus_wdata[oc_bit(gi)]),
         .gate_en (gate_en),
         .flag    (flags[gi]),
         .out_en  (out_en[gi])
      );
   end

   pfr_read_mux #(
      .DW       (DATA_W),
      .AW       (ADDR_W),
      .CTRL_ADR (CTRL_ADDR),
      .STAT_ADR (STAT_ADDR)
   ) u_rmux (
      .rd       (bus_rd),
      .addr     (bus_addr),
      .stage_en (stage_en),
      .slew     (slew),
      .flags    (flags),
      .lin_cl   (lin_cur_lim),
      .lv       (low_volt),
      .hv       (high_volt),
      .therm    (therm_flag),
      .rdata    (bus_rdata)
   );

   AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0)); // R10
   AST_CTRL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == CTRL_ADDR) |-> (bus_rdata[4:0] == '0)); // R2
   AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !stage_en |-> (out_en == '0)); // R8
   AST_OTHER_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr != CTRL_ADDR && !irq_req) |=> $stable(stage_en) && $stable(slew_sel) && $stable(stop_req)); // R10

endmodule

// File: tb/pwr_fault_regs_bench.sv
module pwr_fault_regs_bench;

   localparam int PERIOD = 10;
   localparam int OCP [4] = '{1, 4, 5, 7};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr = '0, wdata = '0;
   logic       wr = 1'b0, rd = 1'b0, irq = 1'b0;
   logic [3:0] ev = '0;
   logic       lincl = 1'b0, lv = 1'b0, hv = 1'b0, th = 1'b0;
   logic [7:0] rdata;
   logic       stage_en, stop_req;
   logic [1:0] slew_sel;
   logic [3:0] out_en;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // behavioural reference state
   bit       m_en, m_stop;
   bit [1:0] m_slew;
   bit [3:0] m_oc;

   always #(PERIOD/2) clk = ~clk;

   pwr_fault_regs u_pwr_fault_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
      .bus_wr(wr), .bus_rd(rd), .bus_rdata(rdata), .oc_event(ev),
      .lin_cur_lim(lincl), .low_volt(lv), .high_volt(hv), .therm_flag(th),
      .irq_req(irq), .stage_en(stage_en), .slew_sel(slew_sel),
      .stop_req(stop_req), .out_en(out_en)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_stop = 0; m_slew = 0; m_oc = 0;
      end else begin
         for (int i = 0; i < 4; i++)
            m_oc[i] = ev[i] || (m_oc[i] && !(wr && addr == 8'h0C && wdata[OCP[i]]));
         if (irq) m_stop = 0;
         else if (wr && addr == 8'h03 && wdata[4]) m_stop = 1;
         if (wr && addr == 8'h03) begin
            m_en = wdata[7]; m_slew = wdata[6:5];
         end
      end
   end

   function automatic logic [7:0] exp_rd();
      logic [7:0] v = '0;
      if (rd && addr == 8'h03) v = {m_en, m_slew, 5'b0};
      else if (rd && addr == 8'h0C) begin
         v = {1'b0, lincl, 2'b00, lv, hv, 1'b0, th};
         for (int i = 0; i < 4; i++) v[OCP[i]] = m_oc[i];
      end
      return v;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 stage_en", stage_en, m_en);
         chk("R2 slew_sel", slew_sel, m_slew);
         chk("R3 stop_req", stop_req, m_stop);
         chk("R8 out_en", out_en, {4{m_en}} & ~m_oc);
         chk("R9 rdata", rdata, exp_rd());
      end
   end

   task automatic cyc(input logic [7:0] a, input logic [7:0] d, input logic w,
                      input logic r, input logic [3:0] e, input logic i);
      addr = a; wdata = d; wr = w; rd = r; ev = e; irq = i;
      @(posedge clk); #1;
      addr = 0; wdata = 0; wr = 0; rd = 0; ev = 0; irq = 0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string tag);
      addr = a; rd = 1'b1; #1;
      chk(tag, rdata, e);
      @(posedge clk); #1;
      rd = 1'b0; addr = 0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(PERIOD * 150000);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk("R1 stage_en", stage_en, 0);
      chk("R1 stop_req", stop_req, 0);
      chk("R1 out_en", out_en, 0);
      chk("R1 slew", slew_sel, 0);
      rd_chk(8'h03, 8'h00, "R1 ctrl read");
      rd_chk(8'h0C, 8'h00, "R1 stat read");
      // R2 control fields
      cyc(8'h03, 8'hE0, 1, 0, 0, 0);
      chk("R2 enable", stage_en, 1);
      chk("R2 slew fast4", slew_sel, 2'b11);
      chk("R8 all on", out_en, 4'hF);
      rd_chk(8'h03, 8'hE0, "R2 ctrl read");
      // R3 stop command, low bits read 0
      cyc(8'h03, 8'hBF, 1, 0, 0, 0);
      chk("R3 stop set", stop_req, 1);
      chk("R2 slew slow", slew_sel, 2'b01);
      rd_chk(8'h03, 8'hA0, "R3 ctrl read hides stop");
      cyc(8'h03, 8'hA0, 1, 0, 0, 0);
      chk("R3 write 0 keeps stop", stop_req, 1);
      // R4 interrupt clears, and beats a simultaneous command
      cyc(8'h00, 8'h00, 0, 0, 0, 1);
      chk("R4 irq clears", stop_req, 0);
      cyc(8'h03, 8'h90, 1, 0, 0, 1);
      chk("R4 irq wins", stop_req, 0);
      chk("R2 slew nominal", slew_sel, 2'b00);
      // R5 event latches
      cyc(8'h00, 8'h00, 0, 0, 4'b0001, 0);
      chk("R5 hb flag gates", out_en, 4'b1110);
      cyc(8'h00, 8'h00, 0, 0, 0, 0);
      chk("R5 sticky", out_en, 4'b1110);
      rd_chk(8'h0C, 8'h02, "R5 stat read");
      // R6 write-one-to-clear
      cyc(8'h0C, 8'h00, 1, 0, 0, 0);
      rd_chk(8'h0C, 8'h02, "R6 write 0 no effect");
      cyc(8'h0C, 8'hFD, 1, 0, 0, 0);
      rd_chk(8'h0C, 8'h02, "R6 other bits no effect");
      cyc(8'h0C, 8'h02, 1, 0, 0, 0);
      chk("R6 cleared", out_en, 4'hF);
      // R7 set wins over clear
      cyc(8'h00, 8'h00, 0, 0, 4'b1000, 0);
      cyc(8'h0C, 8'h80, 1, 0, 4'b1000, 0);
      rd_chk(8'h0C, 8'h80, "R7 set wins");
      chk("R7 output held off", out_en, 4'b0111);
      cyc(8'h0C, 8'h80, 1, 0, 0, 0);
      chk("R7 later clear", out_en, 4'hF);
      // R9 live bits and layout
      lincl = 1; lv = 1; th = 1;
      cyc(8'h00, 8'h00, 0, 0, 4'b0110, 0);
      rd_chk(8'h0C, 8'h79, "R9 layout");
      hv = 1; lincl = 0;
      rd_chk(8'h0C, 8'h3D, "R9 live follow");
      cyc(8'h0C, 8'h30, 1, 0, 0, 0);
      lincl = 0; lv = 0; hv = 0; th = 0;
      // R10 other addresses and idle read
      cyc(8'h05, 8'hFF, 1, 0, 0, 0);
      rd_chk(8'h03, 8'h80, "R10 foreign write ignored");
      rd_chk(8'h05, 8'h00, "R10 foreign read");
      addr = 8'h03; #1;
      chk("R10 idle rdata", rdata, 0);
      // R8 master off
      cyc(8'h03, 8'h00, 1, 0, 0, 0);
      chk("R8 master off", out_en, 0);
      // random traffic compared against the model every cycle
      for (int n = 0; n < 2000; n++) begin
         logic [7:0] a;
         logic [3:0] e;
         case ($urandom_range(0, 3))
            0, 1:    a = 8'h03;
            2:       a = 8'h0C;
            default: a = 8'($urandom);
         endcase
         e = 4'($urandom) & 4'($urandom) & 4'($urandom);
         lincl = 1'($urandom); lv = 1'($urandom);
         hv = 1'($urandom); th = 1'($urandom);
         cyc(a, 8'($urandom), 1'($urandom), 1'($urandom), e,
             ($urandom_range(0, 7) == 0));
      end
      repeat (2) @(posedge clk);
      #1 finish_run();
   end

endmodule